// File: doc/BRIEF.md
# LIN Slave Header Break and Synch Timer

This block sits between the serial receive pin and a UART receiver on the slave side of a LIN bus. Software enables it, selects slave operation and arms it with a one-cycle `arm` pulse. Once armed, the block looks for a break, which is a low level on the line that lasts at least a programmable number of clock samples. When it finds one, it moves straight into timing the synch byte (55h) that follows.

The synch byte is timed with a clock counter. The counter starts at the falling edge of the start bit and stops at the fifth falling edge, which is the start of data bit 7. The count therefore covers eight bit times, and software divides it to derive the bus bit rate. The count is held in a read-only output. When the measurement is done, the block goes idle until the next `arm`.

Two sticky flags report the break and the end of the measurement. Each flag has its own write-1 clear strobe and its own interrupt enable. A control input decides whether the UART sees the synch byte or sees an idle-high line while the measurement runs.

Top module: `lin_hdr_det`

## Requirements
- R1: After reset, `brk_flag`, `sync_flag`, `sync_busy` and `irq` are 0, `sync_count` is 0, and `uart_rxd` is 1.
- R2: Before an `arm` pulse, a low level on `rxd_in` of any length sets no flag and starts no measurement.
- R3: Once armed, a break is detected on the sample where `rxd_in` has been low for `brk_thresh` consecutive clock samples. A run of `brk_thresh`-1 low samples is not detected. Any high sample restarts the low-run count.
- R4: The block does nothing when `lin_en` is 0 or `master_sel` is 1. In that state `arm` is ignored and `sync_busy` drops on the next cycle.
- R5: A detected break sets `brk_flag`. The flag stays set until a cycle with `clr_brk`=1. That clear does not affect `sync_flag`.
- R6: `sync_busy` is 1 from the cycle after break detection until the measurement result is latched.
- R7: `sync_count` equals the number of clock cycles from the falling edge of the synch start bit to the fifth falling edge of the synch byte. For bit times of B cycles, this is 8·B.
- R8: Completing the measurement sets `sync_flag`. The flag stays set until a cycle with `clr_sync`=1.
- R9: `irq` is 1 exactly when (`brk_flag` and `brk_ie`) or (`sync_flag` and `sync_ie`).
- R10: `uart_rxd` follows `rxd_in` two clock cycles later. The one exception is while `sync_busy` is 1 and `pass_sync` is 0; then `uart_rxd` is held at 1.
- R11: After a measurement completes, the block is idle. A further break does nothing until the next `arm`.
- R12: `sync_count` saturates at all ones (2^CNT_W-1) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lin_en | input | 1 | Function enable |
| master_sel | input | 1 | 1 selects master operation, which disables this block |
| arm | input | 1 | One-cycle pulse that starts the break hunt |
| brk_thresh | input | BRK_W | Minimum low run, in clock samples, that counts as a break |
| brk_ie | input | 1 | Interrupt enable for `brk_flag` |
| sync_ie | input | 1 | Interrupt enable for `sync_flag` |
| pass_sync | input | 1 | 1 forwards the synch byte to the UART; 0 holds the UART input high |
| clr_brk | input | 1 | Write-1 clear for `brk_flag` |
| clr_sync | input | 1 | Write-1 clear for `sync_flag` |
| rxd_in | input | 1 | Asynchronous serial receive line |
| uart_rxd | output | 1 | Receive line as seen by the UART |
| sync_busy | output | 1 | Synch measurement in progress |
| brk_flag | output | 1 | Break detected |
| sync_flag | output | 1 | Synch measurement done |
| irq | output | 1 | Interrupt request |
| sync_count | output | CNT_W | Measured eight-bit-time count |

## Verification
The properties assume that `arm` is not pulsed during a measurement the bench expects to finish. They also assume that each synch bit lasts long enough that every edge reaches the synchroniser output as a distinct sample. The bench drives all inputs on the falling clock edge. It holds each bit for a whole number of cycles well above two, and it pulses `arm` only while the line is idle high. Because of this, the break run lengths and the 8·B counts that the bench predicts are exact, with no sampling uncertainty.

// File: rtl/lin_hdr_det.sv
module lin_hdr_det #(
  parameter int BRK_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lin_en,
  input  logic             master_sel,
  input  logic             arm,
  input  logic [BRK_W-1:0] brk_thresh,
  input  logic             brk_ie,
  input  logic             sync_ie,
  input  logic             pass_sync,
  input  logic             clr_brk,
  input  logic             clr_sync,
  input  logic             rxd_in,
  output logic             uart_rxd,
  output logic             sync_busy,
  output logic             brk_flag,
  output logic             sync_flag,
  output logic             irq,
  output logic [CNT_W-1:0] sync_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_BRK, S_SYNC} state_t;

  state_t           st;
  logic             s1, s2, s3;
  logic [BRK_W-1:0] brk_cnt;
  logic [CNT_W-1:0] meas;
  logic [2:0]       falls;

  wire active  = lin_en & ~master_sel;
  wire fall    = s3 & ~s2;
  wire brk_hit = ~s2 && (({1'b0, brk_cnt} + 1'b1) >= {1'b0, brk_thresh});

  assign sync_busy = (st == S_SYNC);
  assign uart_rxd  = (sync_busy && !pass_sync) ? 1'b1 : s2;
  assign irq       = (brk_flag & brk_ie) | (sync_flag & sync_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1         <= 1'b1;
      s2         <= 1'b1;
      s3         <= 1'b1;
      st         <= S_IDLE;
      brk_cnt    <= '0;
      meas       <= '0;
      falls      <= '0;
      sync_count <= '0;
      brk_flag   <= 1'b0;
      sync_flag  <= 1'b0;
    end else begin
      s1 <= rxd_in;
      s2 <= s1;
      s3 <= s2;
      if (clr_brk)  brk_flag  <= 1'b0;
      if (clr_sync) sync_flag <= 1'b0;
      if (!active) begin
        st <= S_IDLE;
      end else if (arm) begin
        st      <= S_BRK;
        brk_cnt <= '0;
      end else begin
        case (st)
          S_BRK: begin
            if (s2) begin
              brk_cnt <= '0;
            end else if (brk_hit) begin
              st       <= S_SYNC;
              brk_flag <= 1'b1;
              falls    <= '0;
              meas     <= '0;
            end else begin
              brk_cnt <= brk_cnt + 1'b1;
            end
          end
          S_SYNC: begin
            if (falls == 3'd0) begin
              if (fall) begin
                falls <= 3'd1;
                meas  <= {{(CNT_W-1){1'b0}}, 1'b1};
              end
            end else if (fall && falls == 3'd4) begin
              sync_count <= meas;
              sync_flag  <= 1'b1;
              st         <= S_IDLE;
            end else begin
              if (fall) falls <= falls + 1'b1;
              if (meas != CNT_MAX) meas <= meas + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lin_hdr_det_chk.sv
module lin_hdr_det_chk (
  input logic clk,
  input logic rst_n,
  input logic lin_en,
  input logic brk_ie,
  input logic pass_sync,
  input logic clr_brk,
  input logic clr_sync,
  input logic uart_rxd,
  input logic sync_busy,
  input logic brk_flag,
  input logic sync_flag,
  input logic irq
);
  assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lin_en |=> !sync_busy);
  assert_brk_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag && !clr_brk |=> brk_flag);
  assert_busy_on_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> sync_busy);
  assert_sync_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_flag && !clr_sync |=> sync_flag);
  assert_irq_on_brk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag && brk_ie |-> irq);
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_flag && !sync_flag |-> !irq);
  assert_uart_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_busy && !pass_sync |-> uart_rxd);
  assert_idle_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_flag) |-> !sync_busy);
endmodule

bind lin_hdr_det lin_hdr_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lin_en(lin_en), .brk_ie(brk_ie),
  .pass_sync(pass_sync), .clr_brk(clr_brk), .clr_sync(clr_sync),
  .uart_rxd(uart_rxd), .sync_busy(sync_busy), .brk_flag(brk_flag),
  .sync_flag(sync_flag), .irq(irq)
);

// File: tb/lin_hdr_det_tb.sv
module lin_hdr_det_tb;
  localparam int BW = 16;
  localparam int CW = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic lin_en = 1, master_sel = 0, arm = 0;
  logic [BW-1:0] brk_thresh = 20;
  logic brk_ie = 0, sync_ie = 0, pass_sync = 1, clr_brk = 0, clr_sync = 0, rxd_in = 1;
  logic uart_rxd, sync_busy, brk_flag, sync_flag, irq;
  logic [CW-1:0] sync_count;

  int total = 0, fails = 0;
  int exp_q[$];
  logic prev_sf = 0;

  always #2.5 clk = ~clk;

  lin_hdr_det #(.BRK_W(BW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lin_en(lin_en), .master_sel(master_sel), .arm(arm),
    .brk_thresh(brk_thresh), .brk_ie(brk_ie), .sync_ie(sync_ie), .pass_sync(pass_sync),
    .clr_brk(clr_brk), .clr_sync(clr_sync), .rxd_in(rxd_in), .uart_rxd(uart_rxd),
    .sync_busy(sync_busy), .brk_flag(brk_flag), .sync_flag(sync_flag), .irq(irq),
    .sync_count(sync_count)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_arm();
    arm = 1; wait_n(1); arm = 0; wait_n(1);
  endtask

  task automatic low_run(int n);
    rxd_in = 0; wait_n(n); rxd_in = 1; wait_n(5);
  endtask

  task automatic send_hdr(int brk, int b, bit pass, bit expect_meas);
    logic [9:0] frame;
    frame = {1'b1, 8'h55, 1'b0};
    if (expect_meas) exp_q.push_back((8 * b > CMAX) ? CMAX : 8 * b);
    rxd_in = 0; wait_n(brk);
    rxd_in = 1; wait_n(b);
    for (int i = 0; i < 10; i++) begin
      rxd_in = frame[i];
      wait_n(b / 2);
      if (i == 0 && expect_meas) begin
        chk("R6 busy during synch", sync_busy, 1);
        chk("R10 uart view of start bit", uart_rxd, pass ? 0 : 1);
      end
      wait_n(b - b / 2);
    end
    rxd_in = 1;
    wait_n(8);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (sync_flag && !prev_sf) begin
        if (exp_q.size() == 0) chk("R7 unexpected result", 1, 0);
        else chk("R7 sync_count", sync_count, exp_q.pop_front());
      end
      prev_sf = sync_flag;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    wait_n(4); rst_n = 1; wait_n(1);
    chk("R1 brk_flag", brk_flag, 0);
    chk("R1 sync_flag", sync_flag, 0);
    chk("R1 sync_busy", sync_busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sync_count", sync_count, 0);
    chk("R1 uart_rxd", uart_rxd, 1);

    low_run(60);
    chk("R2 no break before arm", brk_flag, 0);
    chk("R2 no measurement before arm", sync_busy, 0);

    lin_en = 0; pulse_arm(); low_run(60);
    chk("R4 disabled ignores arm", brk_flag, 0);
    lin_en = 1; master_sel = 1; pulse_arm(); low_run(60);
    chk("R4 master ignores arm", brk_flag, 0);
    master_sel = 0;

    pulse_arm();
    low_run(19);
    chk("R3 run one short", brk_flag, 0);
    rxd_in = 0; wait_n(19); rxd_in = 1; wait_n(1);
    rxd_in = 0; wait_n(19); rxd_in = 1; wait_n(5);
    chk("R3 high sample restarts", brk_flag, 0);
    send_hdr(20, 16, 1, 1);
    chk("R5 brk_flag set", brk_flag, 1);
    chk("R8 sync_flag set", sync_flag, 1);
    chk("R11 idle after done", sync_busy, 0);
    chk("R7 count 8 bit times", sync_count, 128);

    brk_ie = 1; wait_n(1);
    chk("R9 irq from break", irq, 1);
    brk_ie = 0; wait_n(1);
    chk("R9 irq masked", irq, 0);
    sync_ie = 1; wait_n(1);
    chk("R9 irq from synch", irq, 1);
    clr_brk = 1; wait_n(1); clr_brk = 0; wait_n(1);
    chk("R5 clr_brk clears", brk_flag, 0);
    chk("R5 sync_flag untouched", sync_flag, 1);
    clr_sync = 1; wait_n(1); clr_sync = 0; wait_n(1);
    chk("R8 clr_sync clears", sync_flag, 0);
    chk("R9 irq low after clears", irq, 0);
    sync_ie = 0;

    send_hdr(40, 16, 1, 0);
    chk("R11 no break without rearm", brk_flag, 0);
    chk("R11 count kept", sync_count, 128);

    pass_sync = 0; pulse_arm();
    send_hdr(25, 12, 0, 1);
    chk("R7 count at 12-cycle bits", sync_count, 96);
    rxd_in = 0; wait_n(3);
    chk("R10 idle forwards low", uart_rxd, 0);
    rxd_in = 1; wait_n(3);
    chk("R10 idle forwards high", uart_rxd, 1);
    pass_sync = 1;

    clr_brk = 1; clr_sync = 1; wait_n(1); clr_brk = 0; clr_sync = 0;
    pulse_arm();
    send_hdr(20, 200, 1, 1);
    chk("R12 saturated count", sync_count, CMAX);
    chk("R7 all results seen", exp_q.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule